// File: doc/BRIEF.md
# Domain power-up sequencer

This block is a hardware state machine that wakes one power domain from the off state in a fixed order. A one-cycle start pulse carries a domain index. The sequencer first holds the domain in reset. It then asks for power and turns on the domain's clock. After a settling interval it issues a clamp-release command. After a second settling interval it lets the domain out of reset. Each settling interval is a fixed number of microseconds. It is turned into clock cycles from a clock-frequency parameter, rounded up.

The sequence ends with a one-cycle done pulse on success. If a step fails, the sequence ends with a one-cycle error pulse and a code that names the failing step. A failure after power was requested unwinds the steps already taken, in reverse order. The domain's reset is never released on any error path. Two domains have their clamp controls wired crosswise, and the sequencer routes the clamp-release command to the swapped position for those two. The power switch and the clock source are outside this block. They report back through a per-domain powered-status input and two fault inputs.

Top module: `pwr_domain_seq`

## Requirements
- R1: A start whose index is NUM_DOM (7) or larger raises err_o with err_code_o = 1 one cycle after the start edge. No domain output changes.
- R2: For a valid index, the domain's reset output rises one cycle after the start edge. Its power request rises one cycle later and its clock enable one cycle after that. The clock enable is only ever high while the power request of the same domain is high.
- R3: The clamp-release pulse comes exactly W+1 cycles after the clock enable rises, where W = ceil(CLK_HZ * WAIT_US / 1e6), with a minimum of 1.
- R4: The domain's reset output falls exactly W+1 cycles after the clamp-release pulse. done_o pulses in that same cycle, and a reset output never falls at any other time.
- R5: If the selected domain's powered-status bit is already 1 when power would be requested, err_o pulses with code 2. The pulse comes one cycle after the reset output rose, and no power request is raised.
- R6: If clk_fault_i is high in the clock step, the clock is not enabled. One cycle later the power request drops and err_o pulses with code 3. A power request only ever falls together with an error pulse of code 3 or 4.
- R7: If clamp_fault_i is high in the clamp step, no clamp pulse is issued. The clock enable drops one cycle later, then the power request drops and err_o pulses with code 4 one cycle after that.
- R8: The domain's reset output stays high after every error outcome and does not change in the cycle of an error pulse.
- R9: The clamp-release output is a one-cycle pulse on at most one bit. Domain SWAP_A (3) pulses bit SWAP_B (4), domain SWAP_B pulses bit SWAP_A, and every other domain pulses its own bit. A bit pulses only while the domain that owns it has its clock enabled.
- R10: done_o and err_o are single-cycle pulses that are never high together. err_code_o is 0 whenever err_o is low.
- R11: A start pulse that arrives while a sequence is running is ignored. The running sequence keeps its timing, and the other domain is untouched.
- R12: While rst is high and right after it, all domain outputs, done_o, err_o and err_code_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to power up a domain |
| dom_idx_i | input | IDX_W | Index of the domain to power up, sampled with start_i |
| dom_powered_i | input | NUM_DOM | Per-domain powered status from the power switch |
| clk_fault_i | input | 1 | Clock enable step failed, sampled in the clock step |
| clamp_fault_i | input | 1 | Clamp release step failed, sampled in the clamp step |
| dom_rst_o | output | NUM_DOM | Per-domain reset, high holds the domain in reset |
| dom_pwr_req_o | output | NUM_DOM | Per-domain power-on request level |
| dom_clk_en_o | output | NUM_DOM | Per-domain clock enable level |
| dom_clamp_rel_o | output | NUM_DOM | One-cycle clamp-release command per clamp position |
| done_o | output | 1 | One-cycle pulse: sequence completed |
| err_o | output | 1 | One-cycle pulse: sequence ended with an error |
| err_code_o | output | 3 | Failing step: 1 index, 2 already powered, 3 clock, 4 clamp |

## Verification
Every index from 0 to 7 is run through four patterns. The first is a clean power-up with all other domains reported powered, which shows that only the selected status bit matters. The other three are the selected domain already powered, a clock fault, and a clamp fault. Index 7 shows that the range check comes before every other step. The clean runs measure the exact spacing of the clamp pulse and the reset release against a wait count derived from a frequency that needs rounding up, and they show which clamp bit each index drives. One extra run sends a second start to another domain in the middle of a sequence, to show that it is ignored.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PWR,
        ST_CLK,
        ST_WAIT_A,
        ST_CLAMP,
        ST_WAIT_B,
        ST_REL,
        ST_UNDO_CLK,
        ST_UNDO_PWR
    } seq_state_e;

    typedef enum logic [2:0] {
        CODE_NONE    = 3'd0,
        CODE_INDEX   = 3'd1,
        CODE_POWERED = 3'd2,
        CODE_CLOCK   = 3'd3,
        CODE_CLAMP   = 3'd4
    } result_code_e;

    // One command per cycle from the controller to the domain bank.
    typedef struct packed {
        logic set_rst;
        logic clr_rst;
        logic set_pwr;
        logic clr_pwr;
        logic set_clk;
        logic clr_clk;
        logic clamp;
    } dom_cmd_t;

    // Settling interval in cycles, rounded up, never below one.
    function automatic longint unsigned settle_cycles(longint unsigned hz,
                                                      longint unsigned us);
        longint unsigned c;
        c = (hz * us + 64'd999_999) / 64'd1_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

    // Clamp position used by domain d (two domains are wired crosswise).
    function automatic int clamp_slot(int d, int a, int b);
        if (d == a) return b;
        if (d == b) return a;
        return d;
    endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int              CNT_W  = 4,
    parameter logic [CNT_W-1:0] RELOAD = '0
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= RELOAD;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int NUM_DOM = 7,
    parameter int IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [NUM_DOM-1:0] powered_i,
    input  logic               clk_fault_i,
    input  logic               clamp_fault_i,
    input  logic               timer_expired_i,
    output logic               timer_load_o,
    output logic               timer_run_o,
    output dom_cmd_t           cmd_o,
    output logic [IDX_W-1:0]   sel_o,
    output logic               done_o,
    output logic               err_o,
    output result_code_e       code_o
);

    localparam logic [IDX_W:0] IDX_LIM = (IDX_W+1)'(NUM_DOM);

    seq_state_e   state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    result_code_e pend_q, pend_d;
    logic         done_d, err_d;
    result_code_e code_d;
    logic         idx_ok;

    assign idx_ok = ({1'b0, idx_i} < IDX_LIM);

    always_comb begin
        state_d      = state_q;
        idx_d        = idx_q;
        pend_d       = pend_q;
        cmd_o        = '0;
        sel_o        = idx_q;
        timer_load_o = 1'b0;
        timer_run_o  = 1'b0;
        done_d       = 1'b0;
        err_d        = 1'b0;
        code_d       = CODE_NONE;
        unique case (state_q)
            ST_IDLE: begin
                sel_o = idx_i;
                if (start_i) begin
                    if (idx_ok) begin
                        cmd_o.set_rst = 1'b1;
                        idx_d         = idx_i;
                        state_d       = ST_PWR;
                    end else begin
                        err_d  = 1'b1;
                        code_d = CODE_INDEX;
                    end
                end
            end
            ST_PWR: begin
                if (powered_i[idx_q]) begin
                    err_d   = 1'b1;
                    code_d  = CODE_POWERED;
                    state_d = ST_IDLE;
                end else begin
                    cmd_o.set_pwr = 1'b1;
                    state_d       = ST_CLK;
                end
            end
            ST_CLK: begin
                if (clk_fault_i) begin
                    pend_d  = CODE_CLOCK;
                    state_d = ST_UNDO_PWR;
                end else begin
                    cmd_o.set_clk = 1'b1;
                    timer_load_o  = 1'b1;
                    state_d       = ST_WAIT_A;
                end
            end
            ST_WAIT_A: begin
                timer_run_o = 1'b1;
                if (timer_expired_i) state_d = ST_CLAMP;
            end
            ST_CLAMP: begin
                if (clamp_fault_i) begin
                    pend_d  = CODE_CLAMP;
                    state_d = ST_UNDO_CLK;
                end else begin
                    cmd_o.clamp  = 1'b1;
                    timer_load_o = 1'b1;
                    state_d      = ST_WAIT_B;
                end
            end
            ST_WAIT_B: begin
                timer_run_o = 1'b1;
                if (timer_expired_i) state_d = ST_REL;
            end
            ST_REL: begin
                cmd_o.clr_rst = 1'b1;
                done_d        = 1'b1;
                state_d       = ST_IDLE;
            end
            ST_UNDO_CLK: begin
                cmd_o.clr_clk = 1'b1;
                state_d       = ST_UNDO_PWR;
            end
            ST_UNDO_PWR: begin
                cmd_o.clr_pwr = 1'b1;
                err_d         = 1'b1;
                code_d        = pend_q;
                state_d       = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            pend_q  <= CODE_NONE;
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            code_o  <= CODE_NONE;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pend_q  <= pend_d;
            done_o  <= done_d;
            err_o   <= err_d;
            code_o  <= code_d;
        end
    end

endmodule

// File: rtl/pwrseq_bank.sv
module pwrseq_bank
    import pwrseq_pkg::*;
#(
    parameter int NUM_DOM = 7,
    parameter int IDX_W   = 3,
    parameter int SWAP_A  = 3,
    parameter int SWAP_B  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  dom_cmd_t           cmd_i,
    input  logic [IDX_W-1:0]   sel_i,
    output logic [NUM_DOM-1:0] rst_o,
    output logic [NUM_DOM-1:0] pwr_o,
    output logic [NUM_DOM-1:0] clk_o,
    output logic [NUM_DOM-1:0] clamp_o
);

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        // Domain whose clamp-release lands on position i.
        localparam int SRC = clamp_slot(i, SWAP_A, SWAP_B);

        logic hit, clamp_hit;
        assign hit       = (sel_i == IDX_W'(i));
        assign clamp_hit = (sel_i == IDX_W'(SRC));

        always_ff @(posedge clk) begin
            if (rst) begin
                rst_o[i]   <= 1'b0;
                pwr_o[i]   <= 1'b0;
                clk_o[i]   <= 1'b0;
                clamp_o[i] <= 1'b0;
            end else begin
                if (hit && cmd_i.set_rst)      rst_o[i] <= 1'b1;
                else if (hit && cmd_i.clr_rst) rst_o[i] <= 1'b0;

                if (hit && cmd_i.set_pwr)      pwr_o[i] <= 1'b1;
                else if (hit && cmd_i.clr_pwr) pwr_o[i] <= 1'b0;

                if (hit && cmd_i.set_clk)      clk_o[i] <= 1'b1;
                else if (hit && cmd_i.clr_clk) clk_o[i] <= 1'b0;

                clamp_o[i] <= clamp_hit && cmd_i.clamp;
            end
        end
    end

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq
    import pwrseq_pkg::*;
#(
    parameter int              NUM_DOM = 7,
    parameter int              IDX_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
    parameter longint unsigned CLK_HZ  = 100_000_000,
    parameter longint unsigned WAIT_US = 10,
    parameter int              SWAP_A  = 3,
    parameter int              SWAP_B  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [IDX_W-1:0]   dom_idx_i,
    input  logic [NUM_DOM-1:0] dom_powered_i,
    input  logic               clk_fault_i,
    input  logic               clamp_fault_i,
    output logic [NUM_DOM-1:0] dom_rst_o,
    output logic [NUM_DOM-1:0] dom_pwr_req_o,
    output logic [NUM_DOM-1:0] dom_clk_en_o,
    output logic [NUM_DOM-1:0] dom_clamp_rel_o,
    output logic               done_o,
    output logic               err_o,
    output logic [2:0]         err_code_o
);

    localparam longint unsigned WAIT_CYC = settle_cycles(CLK_HZ, WAIT_US);
    localparam int              CNT_W    = $clog2(WAIT_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD  = CNT_W'(WAIT_CYC - 1);

    dom_cmd_t         cmd;
    logic [IDX_W-1:0] sel;
    logic             t_load, t_run, t_exp;
    result_code_e     code;

    pwrseq_ctrl #(
        .NUM_DOM(NUM_DOM),
        .IDX_W  (IDX_W)
    ) u_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .idx_i          (dom_idx_i),
        .powered_i      (dom_powered_i),
        .clk_fault_i    (clk_fault_i),
        .clamp_fault_i  (clamp_fault_i),
        .timer_expired_i(t_exp),
        .timer_load_o   (t_load),
        .timer_run_o    (t_run),
        .cmd_o          (cmd),
        .sel_o          (sel),
        .done_o         (done_o),
        .err_o          (err_o),
        .code_o         (code)
    );

    pwrseq_timer #(
        .CNT_W (CNT_W),
        .RELOAD(RELOAD)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (t_load),
        .run_i    (t_run),
        .expired_o(t_exp)
    );

    pwrseq_bank #(
        .NUM_DOM(NUM_DOM),
        .IDX_W  (IDX_W),
        .SWAP_A (SWAP_A),
        .SWAP_B (SWAP_B)
    ) u_bank (
        .clk    (clk),
        .rst    (rst),
        .cmd_i  (cmd),
        .sel_i  (sel),
        .rst_o  (dom_rst_o),
        .pwr_o  (dom_pwr_req_o),
        .clk_o  (dom_clk_en_o),
        .clamp_o(dom_clamp_rel_o)
    );

    assign err_code_o = code;

endmodule

// File: rtl/pwr_domain_seq_chk.sv
module pwr_domain_seq_chk
    import pwrseq_pkg::*;
#(
    parameter int NUM_DOM = 7,
    parameter int SWAP_A  = 3,
    parameter int SWAP_B  = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_DOM-1:0] dom_rst_o,
    input logic [NUM_DOM-1:0] dom_pwr_req_o,
    input logic [NUM_DOM-1:0] dom_clk_en_o,
    input logic [NUM_DOM-1:0] dom_clamp_rel_o,
    input logic               done_o,
    input logic               err_o,
    input logic [2:0]         err_code_o
);

    // Clock enable of the domain that owns each clamp position.
    logic [NUM_DOM-1:0] clk_at_slot;
    for (genvar i = 0; i < NUM_DOM; i++) begin : g_slot
        assign clk_at_slot[i] = dom_clk_en_o[clamp_slot(i, SWAP_A, SWAP_B)];
    end

    p_clk_needs_pwr_r2: assert property (@(posedge clk) disable iff (rst)
        (dom_clk_en_o & ~dom_pwr_req_o) == '0);

    p_rst_fall_done_r4: assert property (@(posedge clk) disable iff (rst)
        (|($past(dom_rst_o) & ~dom_rst_o)) |-> done_o);

    p_pwr_fall_err_r6: assert property (@(posedge clk) disable iff (rst)
        (|($past(dom_pwr_req_o) & ~dom_pwr_req_o)) |->
            (err_o && (err_code_o == 3'd3 || err_code_o == 3'd4)));

    p_err_rst_stable_r8: assert property (@(posedge clk) disable iff (rst)
        err_o |-> $stable(dom_rst_o));

    p_clamp_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dom_clamp_rel_o));

    p_clamp_owner_clk_r9: assert property (@(posedge clk) disable iff (rst)
        (dom_clamp_rel_o & ~clk_at_slot) == '0);

    p_result_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o));

    p_code_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !err_o |-> (err_code_o == 3'd0));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

bind pwr_domain_seq pwr_domain_seq_chk #(
    .NUM_DOM(NUM_DOM),
    .SWAP_A (SWAP_A),
    .SWAP_B (SWAP_B)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .dom_rst_o      (dom_rst_o),
    .dom_pwr_req_o  (dom_pwr_req_o),
    .dom_clk_en_o   (dom_clk_en_o),
    .dom_clamp_rel_o(dom_clamp_rel_o),
    .done_o         (done_o),
    .err_o          (err_o),
    .err_code_o     (err_code_o)
);

// File: tb/test_pwr_domain_seq.sv
module test_pwr_domain_seq;

    localparam int              CLK_PERIOD = 10;
    localparam int              ND         = 7;
    localparam int              IW         = 3;
    localparam longint unsigned BHZ        = 1_050_000;
    localparam longint unsigned BUS        = 10;
    localparam int              W_EXP      = int'((BHZ * BUS + 64'd999_999) / 64'd1_000_000);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [IW-1:0] dom_idx = '0;
    logic [ND-1:0] powered = '0;
    logic          cfault = 1'b0;
    logic          kfault = 1'b0;
    logic [ND-1:0] d_rst, d_pwr, d_clk, d_clamp;
    logic          done, err;
    logic [2:0]    code;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_domain_seq #(
        .NUM_DOM(ND),
        .IDX_W  (IW),
        .CLK_HZ (BHZ),
        .WAIT_US(BUS),
        .SWAP_A (3),
        .SWAP_B (4)
    ) i_pwr_domain_seq (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start),
        .dom_idx_i      (dom_idx),
        .dom_powered_i  (powered),
        .clk_fault_i    (cfault),
        .clamp_fault_i  (kfault),
        .dom_rst_o      (d_rst),
        .dom_pwr_req_o  (d_pwr),
        .dom_clk_en_o   (d_clk),
        .dom_clamp_rel_o(d_clamp),
        .done_o         (done),
        .err_o          (err),
        .err_code_o     (code)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int slot_of(input int d);
        if (d == 3) return 4;
        if (d == 4) return 3;
        return d;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // mode: 0 clean, 1 already powered, 2 clock fault, 3 clamp fault
    task automatic run_case(input int idx, input int mode, input bit poke);
        int t_rst_on = -1, t_rst_off = -1, t_pwr_on = -1, t_pwr_off = -1;
        int t_clk_on = -1, t_clk_off = -1, t_clamp = -1, t_end = -1;
        int clamp_bit = -1, stray = 0, g_done = 0, g_err = 0, g_code = 0;
        bit ended = 0;
        logic pr = 0, pp = 0, pc = 0;
        logic [ND-1:0] own;
        string tag;
        own = (idx < ND) ? ND'(1) << idx : '0;
        tag = $sformatf("idx %0d mode %0d", idx, mode);
        do_reset();
        powered = (mode == 1) ? own : ~own;
        cfault  = (mode == 2);
        kfault  = (mode == 3);
        start   = 1'b1;
        dom_idx = IW'(idx);
        for (int n = 0; n < 400 && !ended; n++) begin
            @(negedge clk);
            if (idx < ND) begin
                if (d_rst[idx] && !pr && t_rst_on < 0) t_rst_on = n;
                if (!d_rst[idx] && pr) t_rst_off = n;
                if (d_pwr[idx] && !pp && t_pwr_on < 0) t_pwr_on = n;
                if (!d_pwr[idx] && pp) t_pwr_off = n;
                if (d_clk[idx] && !pc && t_clk_on < 0) t_clk_on = n;
                if (!d_clk[idx] && pc) t_clk_off = n;
                pr = d_rst[idx]; pp = d_pwr[idx]; pc = d_clk[idx];
            end
            if ((|d_clamp) && t_clamp < 0) begin
                t_clamp = n;
                for (int b = 0; b < ND; b++) if (d_clamp[b]) clamp_bit = b;
                if ($countones(d_clamp) != 1) clamp_bit = -2;
            end
            if (|((d_rst | d_pwr | d_clk) & ~own)) stray = 1;
            if (done || err) begin
                ended = 1; t_end = n;
                g_done = done; g_err = err; g_code = code;
            end
            start   = poke && (n == 5);
            dom_idx = poke ? IW'(5) : IW'(idx);
        end
        @(negedge clk);
        chk("R10", {tag, " pulse width"}, int'(done | err), 0);
        if (poke) chk("R11", {tag, " other domain untouched"}, stray, 0);
        else      chk("R1",  {tag, " no stray domain"}, stray, 0);
        if (idx >= ND) begin
            chk("R1", {tag, " end cycle"}, t_end, 0);
            chk("R1", {tag, " code"}, g_code, 1);
            chk("R1", {tag, " err"}, g_err, 1);
            chk("R1", {tag, " no clamp"}, t_clamp, -1);
        end else begin
            chk("R2", {tag, " reset rise"}, t_rst_on, 0);
            case (mode)
                0: begin
                    chk("R2", {tag, " power rise"}, t_pwr_on, 1);
                    chk("R2", {tag, " clock rise"}, t_clk_on, 2);
                    chk("R3", {tag, " clamp cycle"}, t_clamp, W_EXP + 3);
                    chk("R9", {tag, " clamp bit"}, clamp_bit, slot_of(idx));
                    chk("R4", {tag, " reset fall"}, t_rst_off, 2 * W_EXP + 4);
                    chk("R4", {tag, " done cycle"}, t_end, 2 * W_EXP + 4);
                    chk("R4", {tag, " done"}, g_done, 1);
                    chk("R10", {tag, " code clean"}, g_code, 0);
                    chk("R4", {tag, " power kept"}, int'(d_pwr[idx]), 1);
                end
                1: begin
                    chk("R5", {tag, " end cycle"}, t_end, 1);
                    chk("R5", {tag, " code"}, g_code, 2);
                    chk("R5", {tag, " no power"}, t_pwr_on, -1);
                end
                2: begin
                    chk("R6", {tag, " no clock"}, t_clk_on, -1);
                    chk("R6", {tag, " power fall"}, t_pwr_off, 3);
                    chk("R6", {tag, " end cycle"}, t_end, 3);
                    chk("R6", {tag, " code"}, g_code, 3);
                end
                default: begin
                    chk("R7", {tag, " no clamp"}, t_clamp, -1);
                    chk("R7", {tag, " clock fall"}, t_clk_off, W_EXP + 4);
                    chk("R7", {tag, " power fall"}, t_pwr_off, W_EXP + 5);
                    chk("R7", {tag, " end cycle"}, t_end, W_EXP + 5);
                    chk("R7", {tag, " code"}, g_code, 4);
                end
            endcase
            if (mode != 0) begin
                chk("R8", {tag, " reset held"}, int'(d_rst[idx]), 1);
                chk("R8", {tag, " reset never fell"}, t_rst_off, -1);
                chk("R8", {tag, " err"}, g_err, 1);
            end
        end
        cfault = 1'b0; kfault = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R12: reset state, during and right after reset
        repeat (3) @(negedge clk);
        chk("R12", "outputs in reset", int'(|{d_rst, d_pwr, d_clk, d_clamp, done, err, code}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "outputs after reset", int'(|{d_rst, d_pwr, d_clk, d_clamp, done, err, code}), 0);
        chk("R3", "derived wait count", W_EXP, 11);

        for (int idx = 0; idx < 8; idx++)
            for (int mode = 0; mode < 4; mode++)
                run_case(idx, mode, 1'b0);

        // R11: second start to domain 5 while domain 2 is running
        run_case(2, 0, 1'b1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule